// File: doc/BRIEF.md
# Round-Robin Bus Request Arbiter with Same-Cycle Grant

This block decides which of several peripherals may use a shared bus. Each peripheral raises its own request line. The arbiter answers with one acknowledge line per peripheral. The arbiter's state (current owner and most recent winner) lives in flops, and the acknowledge is decoded combinationally from that state and the live request lines. As a result, a peripheral that asks for an idle bus is acknowledged in the same cycle it asks. A zero-wait transfer then takes two cycles (request plus grant, then the access) instead of three. Every acknowledge is meant to feed only the D inputs of flops in the peripheral, so the whole path stays single-edge.

A peripheral keeps the bus for as long as it holds its request, or as long as the shared wait-state input is asserted. A peripheral whose access is stretched by wait states therefore never has to request again. When the owner's request and the wait-state input are both low, the bus is free in that same cycle, and any other pending requester is granted at once. Among competing requesters, the search starts just after the most recent winner and wraps around.

Top module: `busReqArbiter`

## Requirements
- R1: In every cycle at most one bit of `ackOut` is high.
- R2: While `rst` is high, `ackOut` is all zero. After reset no port owns the bus, and the priority search begins at port 0.
- R3: With no current owner, if any `reqIn` bit is high, exactly one requesting port sees its `ackOut` bit high in that same cycle.
- R4: A port that was acknowledged in the previous cycle stays acknowledged while its `reqIn` bit stays high, whatever the other ports request.
- R5: A port that was acknowledged in the previous cycle stays acknowledged while `waitIn` is high, even after its `reqIn` bit has dropped.
- R6: Ownership ends in the first cycle in which the owner's `reqIn` bit and `waitIn` are both low. In that cycle the owner's `ackOut` bit is low, and another pending requester is granted in that cycle.
- R7: A new grant goes to the first port with `reqIn` high, searching upward from the port after the most recent winner and wrapping from port NUM_PORTS-1 to port 0.
- R8: `waitIn` has no effect while no port owns the bus: with `reqIn` all zero, `ackOut` stays all zero whatever `waitIn` is.
- R9: A zero-wait access occupies two cycles. The request is acknowledged in the cycle it is raised. When the request drops in the next cycle, the acknowledge drops in that cycle and the bus is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | NUM_PORTS | One request line per peripheral, bit i for port i |
| waitIn | input | 1 | Wait-state input; when high, the current owner keeps the bus |
| ackOut | output | NUM_PORTS | One acknowledge per peripheral, one-hot or zero, decoded combinationally |

## Verification
The assertions assume that `reqIn` and `waitIn` are synchronous to `clk` and settle well before the rising edge. They also assume that `waitIn` is driven on behalf of the current owner, so its meaning while the bus is idle is only "ignore me". The bench changes every input just after the falling edge and samples `ackOut` one time step later. This keeps the combinational acknowledge path clean of edge races. The bench also deliberately raises `waitIn` while no port requests, so that the idle case of the wait-state rule is exercised.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  // Strobes from the control module to the state datapath.
  typedef struct packed {
    logic grant;    // some port is acknowledged this cycle
    logic keep;     // the grant continues the current tenure
  } arbStrobes_t;

endpackage

// File: rtl/busArbPicker.sv
module busArbPicker #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic [IDX_W-1:0]     lastIdx,
  output logic                 found,
  output logic [IDX_W-1:0]     pickIdx
);

  // Rotating priority: scan from the farthest offset to the nearest one,
  // so that the nearest requester after lastIdx wins.
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int k = NUM_PORTS; k >= 1; k--) begin
      int cand;
      cand = int'(lastIdx) + k;
      if (cand >= NUM_PORTS) cand = cand - NUM_PORTS;
      if (reqIn[cand[IDX_W-1:0]]) begin
        found   = 1'b1;
        pickIdx = cand[IDX_W-1:0];
      end
    end
  end

  // R7: whatever is picked must actually be requesting.
  always_comb begin
    if (found) begin
      p_pick_requests_r7: assert (reqIn[pickIdx]);
    end
  end

endmodule

// File: rtl/busArbControl.sv
module busArbControl
  import busarb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic                 waitIn,
  input  logic                 ownerValid,
  input  logic [IDX_W-1:0]     ownerIdx,
  input  logic                 found,
  input  logic [IDX_W-1:0]     pickIdx,
  output arbStrobes_t          strobes,
  output logic [IDX_W-1:0]     grantIdx
);

  logic holdBus;

  // The owner keeps the bus while it still requests or is being stretched.
  assign holdBus = ownerValid && (reqIn[ownerIdx] || waitIn);

  always_comb begin
    strobes.keep  = holdBus && !rst;
    strobes.grant = !rst && (holdBus || found);
    grantIdx      = holdBus ? ownerIdx : pickIdx;
  end

  // R3: an idle bus with a pending request is granted in the same cycle.
  p_idle_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (!ownerValid && (|reqIn)) |-> strobes.grant);

  // R2: nothing is granted while reset is applied.
  always_comb begin
    if (rst) begin
      p_reset_quiet_r2: assert (!strobes.grant);
    end
  end

endmodule

// File: rtl/busArbDatapath.sv
module busArbDatapath
  import busarb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam logic [IDX_W-1:0] LAST_PORT = IDX_W'(NUM_PORTS - 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  arbStrobes_t          strobes,
  input  logic [IDX_W-1:0]     grantIdx,
  output logic                 ownerValid,
  output logic [IDX_W-1:0]     ownerIdx,
  output logic [IDX_W-1:0]     lastIdx,
  output logic [NUM_PORTS-1:0] ackOut
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ownerValid <= 1'b0;
      ownerIdx   <= '0;
      lastIdx    <= LAST_PORT;   // search starts at port 0 after reset
    end else if (strobes.grant) begin
      ownerValid <= 1'b1;
      ownerIdx   <= grantIdx;
      if (!strobes.keep) lastIdx <= grantIdx;
    end else begin
      ownerValid <= 1'b0;
    end
  end

  // Combinational one-hot decode of the grant.
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_ackDecode
    assign ackOut[i] = strobes.grant && (grantIdx == IDX_W'(i));
  end

  // R1: the decode never raises two acknowledges.
  p_ack_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ackOut));

  // R7: the priority pointer only moves onto a port that was granted.
  p_last_follows_grant_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.grant && !strobes.keep) |=> (lastIdx == $past(grantIdx)));

endmodule

// File: rtl/busReqArbiter.sv
module busReqArbiter
  import busarb_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic                 waitIn,
  output logic [NUM_PORTS-1:0] ackOut
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  arbStrobes_t      strobes;
  logic             ownerValid;
  logic [IDX_W-1:0] ownerIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             found;
  logic [IDX_W-1:0] pickIdx;
  logic [IDX_W-1:0] grantIdx;

  busArbPicker #(.NUM_PORTS(NUM_PORTS)) uPicker (
    .reqIn   (reqIn),
    .lastIdx (lastIdx),
    .found   (found),
    .pickIdx (pickIdx)
  );

  busArbControl #(.NUM_PORTS(NUM_PORTS)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .reqIn      (reqIn),
    .waitIn     (waitIn),
    .ownerValid (ownerValid),
    .ownerIdx   (ownerIdx),
    .found      (found),
    .pickIdx    (pickIdx),
    .strobes    (strobes),
    .grantIdx   (grantIdx)
  );

  busArbDatapath #(.NUM_PORTS(NUM_PORTS)) uPath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .grantIdx   (grantIdx),
    .ownerValid (ownerValid),
    .ownerIdx   (ownerIdx),
    .lastIdx    (lastIdx),
    .ackOut     (ackOut)
  );

  // Port-level timing rules, one set per peripheral.
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_portRules
    // R4: a granted port that keeps requesting keeps the bus.
    p_keep_on_req_r4: assert property (@(posedge clk) disable iff (rst)
      ackOut[i] |=> (!reqIn[i] || ackOut[i]));
    // R5: a granted port keeps the bus while the wait-state input is high.
    p_keep_on_wait_r5: assert property (@(posedge clk) disable iff (rst)
      ackOut[i] |=> (!waitIn || ackOut[i]));
    // R6: with request and wait both low, the owner's acknowledge drops.
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
      (!reqIn[i] && !waitIn) |-> !ackOut[i]);
    // R8: an acknowledge needs a live request or a continuing wait-state tenure.
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
      ackOut[i] |-> (reqIn[i] || (waitIn && $past(ackOut[i]))));
  end

endmodule

// File: tb/busReqArbiter_test.sv
module busReqArbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] reqIn;
  logic         waitIn;
  logic [N-1:0] ackOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  // Behavioural model state: -1 means no owner.
  int refOwner;
  int refLast;

  busReqArbiter #(.NUM_PORTS(N)) uut (
    .clk(clk), .rst(rst), .reqIn(reqIn), .waitIn(waitIn), .ackOut(ackOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] modelAck(input logic [N-1:0] r, input logic w,
                                            input logic rs);
    logic [N-1:0] e;
    e = '0;
    if (!rs) begin
      if (refOwner >= 0 && (r[refOwner] || w)) begin
        e[refOwner] = 1'b1;
      end else begin
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (refLast + k) % N;
          if (r[c] && e == '0) e[c] = 1'b1;
        end
      end
    end
    return e;
  endfunction

  function automatic string tagFor(input logic [N-1:0] r, input logic w, input logic rs);
    if (rs) return "R2";
    if (refOwner >= 0 && r[refOwner]) return "R4";
    if (refOwner >= 0 && w) return "R5";
    if (refOwner >= 0) return "R6";
    if (r == '0) return "R8";
    return (refLast == N-1) ? "R3" : "R7";
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: ackOut actual %b expected %b", tag, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, compare, then advance the model.
  task automatic step(input logic [N-1:0] r, input logic w, input logic rs);
    logic [N-1:0] e;
    string tg;
    @(negedge clk);
    reqIn = r; waitIn = w; rst = rs;
    #1;
    e  = modelAck(r, w, rs);
    tg = tagFor(r, w, rs);
    check(tg, ackOut, e);
    nTests++;
    if ($countones(ackOut) > 1) begin
      nFail++;
      $display("FAIL R1: ackOut actual %b expected at most one bit", ackOut);
    end
    @(posedge clk);
    if (rs) begin
      refOwner = -1; refLast = N-1;
    end else if (e != '0) begin
      for (int i = 0; i < N; i++) if (e[i]) begin
        if (refOwner != i) refLast = i;
        refOwner = i;
      end
    end else begin
      refOwner = -1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    refOwner = -1; refLast = N-1;
    rst = 1'b1; reqIn = '0; waitIn = 1'b0;
    // R2: reset holds acknowledges low even with requests present.
    step(4'b1111, 1'b1, 1'b1);
    step(4'b0000, 1'b0, 1'b1);
    step(4'b0000, 1'b0, 1'b0);

    // R8: wait-state with an idle bus does nothing.
    step(4'b0000, 1'b1, 1'b0);

    // R9: zero-wait access on port 2: ack in request cycle, gone next cycle.
    @(negedge clk); reqIn = 4'b0100; waitIn = 1'b0; #1;
    check("R9", ackOut, 4'b0100);
    @(posedge clk); refOwner = 2; refLast = 2;
    @(negedge clk); reqIn = 4'b0000; #1;
    check("R9", ackOut, 4'b0000);
    @(posedge clk); refOwner = -1;

    // R7: after port 2, all requesting -> port 3, then wraps to 0.
    step(4'b1111, 1'b0, 1'b0);  // grant 3
    step(4'b0111, 1'b0, 1'b0);  // release 3, grant 0 same cycle (R6)
    step(4'b0111, 1'b0, 1'b0);  // R4 hold 0
    step(4'b0110, 1'b1, 1'b0);  // R5 hold 0 by wait
    step(4'b0110, 1'b1, 1'b0);
    step(4'b0110, 1'b0, 1'b0);  // R6 release, grant 1
    step(4'b0100, 1'b0, 1'b0);  // release 1, grant 2
    step(4'b0000, 1'b0, 1'b0);

    // Mixed stimulus against the model.
    for (int n = 0; n < 2000; n++) begin
      logic [N-1:0] r;
      logic w, rs;
      r  = N'($urandom);
      w  = ($urandom % 4) == 0;
      rs = ($urandom % 100) == 0;
      step(r, w, rs);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule